// File: doc/BRIEF.md
# Pass Register Processing Element

One processing element of a pipeline stripe. It pairs a narrow ALU with a small file of pass registers that carry data from stripe to stripe. Every clock, the ALU result lands in the one register chosen by the configuration. Every forwarding register that the ALU does not write takes the value of the register with the same index in the upstream element. Values therefore travel down a chain of elements one stripe per clock without using any ALU.

The highest-index register is the feedback register. It is not forwarded from upstream. It keeps its value until the ALU writes it or an external restore loads it, so it is the only state that must be saved out and loaded back when the stripe is swapped. The operation code, the write index and the two read indices are static inputs that stay constant while one configuration is resident. The carry input and carry output let adjacent elements form a wider adder.

Top module: `pe_pass_elem`

## Requirements
- R1: While rst_ni is low, every forwarding register, the feedback register and save_data_o are zero.
- R2: On each clock the register at index cfg_wsel_i takes alu_o. Index NUM_REGS-1 is the feedback register; indices 0 to NUM_REGS-2 are forwarding registers.
- R3: On each clock every forwarding register whose index differs from cfg_wsel_i takes the same-index slice of prev_regs_i. Slice k is bits k*DATA_W and up.
- R4: The feedback register keeps its value when it is neither written nor restored, whatever prev_regs_i does.
- R5: The operand indices cfg_rsel_a_i and cfg_rsel_b_i select slice k of prev_regs_i for k < NUM_REGS-1. The value NUM_REGS-1 selects the element's own feedback register.
- R6: cfg_op_i encodes the operation: 0 is a+b+carry_i, 1 is a+~b+carry_i, 2 is AND, 3 is OR, 4 is XOR, 5 passes a, 6 passes b, 7 gives zero. alu_o is combinational.
- R7: carry_o is bit DATA_W of the sum for codes 0 and 1, and 0 for every other code.
- R8: zero_o is 1 exactly when alu_o is all zeros.
- R9: When restore_en_i is high, the feedback register takes restore_data_i on the next clock. This overrides an ALU write to the feedback register in the same cycle.
- R10: When save_en_i is high, save_data_o shows the feedback register's value from before that clock edge. This holds even if a restore happens on the same edge. Otherwise save_data_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_op_i | input | 3 | ALU operation code |
| cfg_wsel_i | input | clog2(NUM_REGS) | Register written by the ALU |
| cfg_rsel_a_i | input | clog2(NUM_REGS) | Operand A source index |
| cfg_rsel_b_i | input | clog2(NUM_REGS) | Operand B source index |
| carry_i | input | 1 | Carry from neighbour element |
| prev_regs_i | input | (NUM_REGS-1)*DATA_W | Upstream forwarding registers |
| restore_en_i | input | 1 | Load feedback register from restore_data_i |
| restore_data_i | input | DATA_W | Restore value |
| save_en_i | input | 1 | Capture feedback register into save_data_o |
| fwd_regs_o | output | (NUM_REGS-1)*DATA_W | Forwarding registers, to downstream |
| fb_reg_o | output | DATA_W | Feedback register |
| alu_o | output | DATA_W | ALU result |
| carry_o | output | 1 | Carry to neighbour element |
| zero_o | output | 1 | ALU result is zero |
| save_data_o | output | DATA_W | Saved feedback value |

## Verification
The state swap and the ALU path can collide on the feedback register within one cycle. The bench provokes this in one cycle: restore is high, the write index points at the feedback register, and save is also high. It then expects three results. The feedback register takes the restore value, not the ALU sum. save_data_o shows the value from before the edge. All forwarding registers still load from upstream.

// File: rtl/pe_pass_pkg.sv
package pe_pass_pkg;
  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_AND    = 3'd2,
    OP_OR     = 3'd3,
    OP_XOR    = 3'd4,
    OP_PASS_A = 3'd5,
    OP_PASS_B = 3'd6,
    OP_CLEAR  = 3'd7
  } alu_op_e;
endpackage

// File: rtl/pe_alu.sv
module pe_alu
  import pe_pass_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              zero_o
);
  logic [DATA_W:0] sum;
  logic [DATA_W:0] cin_ext;

  assign cin_ext = {{DATA_W{1'b0}}, carry_i};

  always_comb begin
    sum     = '0;
    res_o   = '0;
    carry_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        sum     = {1'b0, a_i} + {1'b0, b_i} + cin_ext;
        res_o   = sum[DATA_W-1:0];
        carry_o = sum[DATA_W];
      end
      OP_SUB: begin
        sum     = {1'b0, a_i} + {1'b0, ~b_i} + cin_ext;
        res_o   = sum[DATA_W-1:0];
        carry_o = sum[DATA_W];
      end
      OP_AND:    res_o = a_i & b_i;
      OP_OR:     res_o = a_i | b_i;
      OP_XOR:    res_o = a_i ^ b_i;
      OP_PASS_A: res_o = a_i;
      OP_PASS_B: res_o = b_i;
      default:   res_o = '0;
    endcase
  end

  assign zero_o = ~|res_o;
endmodule

// File: rtl/pe_operand_sel.sv
module pe_operand_sel #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int IdxW    = $clog2(NUM_REGS),
  localparam int FwdW    = (NUM_REGS - 1) * DATA_W
) (
  input  logic [FwdW-1:0]   prev_i,
  input  logic [DATA_W-1:0] fb_i,
  input  logic [IdxW-1:0]   sel_i,
  output logic [DATA_W-1:0] opnd_o
);
  logic [DATA_W-1:0] src [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS - 1; g++) begin : g_src
    assign src[g] = prev_i[g*DATA_W +: DATA_W];
  end
  // top slot is the own feedback register, not upstream
  assign src[NUM_REGS-1] = fb_i;

  assign opnd_o = src[sel_i];
endmodule

// File: rtl/pe_pass_file.sv
module pe_pass_file #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int IdxW    = $clog2(NUM_REGS),
  localparam int FwdN    = NUM_REGS - 1,
  localparam int FwdW    = FwdN * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IdxW-1:0]   wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [FwdW-1:0]   prev_i,
  input  logic              restore_en_i,
  input  logic [DATA_W-1:0] restore_data_i,
  input  logic              save_en_i,
  output logic [FwdW-1:0]   fwd_o,
  output logic [DATA_W-1:0] fb_o,
  output logic [DATA_W-1:0] save_data_o
);
  logic [DATA_W-1:0] fb_q;
  logic [DATA_W-1:0] save_q;

  for (genvar g = 0; g < FwdN; g++) begin : g_fwd
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     q <= '0;
      else if (wsel_i == IdxW'(g))     q <= wdata_i;
      else                             q <= prev_i[g*DATA_W +: DATA_W];
    end
    assign fwd_o[g*DATA_W +: DATA_W] = q;
  end

  // restore wins over ALU write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          fb_q <= '0;
    else if (restore_en_i)                fb_q <= restore_data_i;
    else if (wsel_i == IdxW'(NUM_REGS-1)) fb_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        save_q <= '0;
    else if (save_en_i) save_q <= fb_q;
  end

  assign fb_o        = fb_q;
  assign save_data_o = save_q;
endmodule

// File: rtl/pe_pass_elem.sv
module pe_pass_elem
  import pe_pass_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int IdxW    = $clog2(NUM_REGS),
  localparam int FwdW    = (NUM_REGS - 1) * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cfg_op_i,
  input  logic [IdxW-1:0]   cfg_wsel_i,
  input  logic [IdxW-1:0]   cfg_rsel_a_i,
  input  logic [IdxW-1:0]   cfg_rsel_b_i,
  input  logic              carry_i,
  input  logic [FwdW-1:0]   prev_regs_i,
  input  logic              restore_en_i,
  input  logic [DATA_W-1:0] restore_data_i,
  input  logic              save_en_i,
  output logic [FwdW-1:0]   fwd_regs_o,
  output logic [DATA_W-1:0] fb_reg_o,
  output logic [DATA_W-1:0] alu_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic [DATA_W-1:0] save_data_o
);
  logic [DATA_W-1:0] opnd_a, opnd_b, fb_val;

  pe_operand_sel #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_sel_a (
    .prev_i(prev_regs_i), .fb_i(fb_val), .sel_i(cfg_rsel_a_i), .opnd_o(opnd_a)
  );

  pe_operand_sel #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_sel_b (
    .prev_i(prev_regs_i), .fb_i(fb_val), .sel_i(cfg_rsel_b_i), .opnd_o(opnd_b)
  );

  pe_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(alu_op_e'(cfg_op_i)), .a_i(opnd_a), .b_i(opnd_b), .carry_i(carry_i),
    .res_o(alu_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  pe_pass_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_file (
    .clk_i(clk_i), .rst_ni(rst_ni), .wsel_i(cfg_wsel_i), .wdata_i(alu_o),
    .prev_i(prev_regs_i), .restore_en_i(restore_en_i),
    .restore_data_i(restore_data_i), .save_en_i(save_en_i),
    .fwd_o(fwd_regs_o), .fb_o(fb_val), .save_data_o(save_data_o)
  );

  assign fb_reg_o = fb_val;
endmodule

// File: rtl/pe_pass_checker.sv
module pe_pass_checker #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int IdxW    = $clog2(NUM_REGS),
  localparam int FwdW    = (NUM_REGS - 1) * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cfg_op_i,
  input logic [IdxW-1:0]   cfg_wsel_i,
  input logic [FwdW-1:0]   prev_regs_i,
  input logic              restore_en_i,
  input logic [DATA_W-1:0] restore_data_i,
  input logic              save_en_i,
  input logic [FwdW-1:0]   fwd_regs_o,
  input logic [DATA_W-1:0] fb_reg_o,
  input logic [DATA_W-1:0] alu_o,
  input logic              carry_o,
  input logic [DATA_W-1:0] save_data_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS - 1; g++) begin : g_chk
    assert_fwd_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(cfg_wsel_i) != IdxW'(g)
      |-> fwd_regs_o[g*DATA_W +: DATA_W] == $past(prev_regs_i[g*DATA_W +: DATA_W]));
    assert_fwd_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(cfg_wsel_i) == IdxW'(g)
      |-> fwd_regs_o[g*DATA_W +: DATA_W] == $past(alu_o));
  end

  assert_fb_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(cfg_wsel_i) == IdxW'(NUM_REGS-1) && !$past(restore_en_i)
    |-> fb_reg_o == $past(alu_o));

  assert_fb_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(cfg_wsel_i) != IdxW'(NUM_REGS-1) && !$past(restore_en_i)
    |-> $stable(fb_reg_o));

  assert_restore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(restore_en_i) |-> fb_reg_o == $past(restore_data_i));

  assert_save_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(save_en_i) |-> save_data_o == $past(fb_reg_o));

  assert_save_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && !$past(save_en_i) |-> $stable(save_data_o));

  assert_logic_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_op_i > 3'd1 |-> !carry_o);
endmodule

bind pe_pass_elem pe_pass_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_op_i(cfg_op_i), .cfg_wsel_i(cfg_wsel_i),
  .prev_regs_i(prev_regs_i), .restore_en_i(restore_en_i),
  .restore_data_i(restore_data_i), .save_en_i(save_en_i),
  .fwd_regs_o(fwd_regs_o), .fb_reg_o(fb_reg_o), .alu_o(alu_o),
  .carry_o(carry_o), .save_data_o(save_data_o)
);

// File: tb/pe_pass_elem_tb_top.sv
`timescale 1ns/1ps
module pe_pass_elem_tb_top;
  localparam int W    = 8;
  localparam int N    = 8;
  localparam int IW   = 3;
  localparam int FW   = (N - 1) * W;
  localparam int FB   = N - 1;

  typedef struct {
    logic [FW-1:0] fwd;
    logic [W-1:0]  fb;
    logic [W-1:0]  save;
    string         tag;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    cfg_op_i = '0;
  logic [IW-1:0] cfg_wsel_i = '0, cfg_rsel_a_i = '0, cfg_rsel_b_i = '0;
  logic          carry_i = 1'b0;
  logic [FW-1:0] prev_regs_i = '0;
  logic          restore_en_i = 1'b0;
  logic [W-1:0]  restore_data_i = '0;
  logic          save_en_i = 1'b0;
  logic [FW-1:0] fwd_regs_o;
  logic [W-1:0]  fb_reg_o, alu_o, save_data_o;
  logic          carry_o, zero_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t q[$];
  logic [FW-1:0] m_fwd = '0;
  logic [W-1:0]  m_fb = '0, m_save = '0;

  always #2 clk_i = ~clk_i;

  pe_pass_elem #(.DATA_W(W), .NUM_REGS(N)) dut_i (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per edge after the driver queued it
  initial forever begin
    @(posedge clk_i);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " fwd"},  64'(fwd_regs_o),  64'(e.fwd));
      check({e.tag, " fb"},   64'(fb_reg_o),    64'(e.fb));
      check({e.tag, " save"}, 64'(save_data_o), 64'(e.save));
    end
  end

  task automatic step(input logic [2:0] op, input int ws, input int ra, input int rb,
                      input logic cin, input logic [FW-1:0] prev, input logic sv,
                      input logic rs, input logic [W-1:0] rd, input string tag);
    logic [W-1:0] a, b, r;
    logic [W:0]   s;
    logic         c;
    exp_t e;
    @(negedge clk_i);
    cfg_op_i = op; cfg_wsel_i = IW'(ws); cfg_rsel_a_i = IW'(ra); cfg_rsel_b_i = IW'(rb);
    carry_i = cin; prev_regs_i = prev; save_en_i = sv; restore_en_i = rs; restore_data_i = rd;
    a = (ra == FB) ? m_fb : prev[ra*W +: W];
    b = (rb == FB) ? m_fb : prev[rb*W +: W];
    s = '0; c = 1'b0;
    case (op)
      3'd0: begin s = {1'b0, a} + {1'b0, b} + (W+1)'(cin); r = s[W-1:0]; c = s[W]; end
      3'd1: begin s = {1'b0, a} + {1'b0, ~b} + (W+1)'(cin); r = s[W-1:0]; c = s[W]; end
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: r = a;
      3'd6: r = b;
      default: r = '0;
    endcase
    #0.5;
    check({tag, " alu R5 R6"}, 64'(alu_o), 64'(r));
    check({tag, " carry R7"}, 64'(carry_o), 64'(c));
    check({tag, " zero R8"},  64'(zero_o),  64'(r == '0));
    if (sv) m_save = m_fb;
    for (int i = 0; i < N - 1; i++)
      m_fwd[i*W +: W] = (i == ws) ? r : prev[i*W +: W];
    if (rs)           m_fb = rd;
    else if (ws == FB) m_fb = r;
    e.fwd = m_fwd; e.fb = m_fb; e.save = m_save; e.tag = tag;
    q.push_back(e);
    @(posedge clk_i);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] p1, p2;
    p1 = 56'h77_66_55_44_33_22_11;
    p2 = 56'h0F_E0_80_7F_01_FF_A5;
    #9;
    check("R1 fwd reset",  64'(fwd_regs_o),  64'h0);
    check("R1 fb reset",   64'(fb_reg_o),    64'h0);
    check("R1 save reset", 64'(save_data_o), 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    step(3'd0, 2, 0, 1, 1'b0, p1, 0, 0, '0, "R2 R3 add");
    step(3'd1, FB, 3, 4, 1'b1, p1, 0, 0, '0, "R2 sub to fb");
    step(3'd2, 0, FB, 5, 1'b0, p2, 0, 0, '0, "R5 and fb operand");
    step(3'd3, 1, 0, 6, 1'b0, p2, 0, 0, '0, "R6 or");
    step(3'd4, 3, 5, 6, 1'b0, p1, 0, 0, '0, "R6 xor");
    step(3'd5, 4, 6, 0, 1'b1, p2, 0, 0, '0, "R6 R7 pass a");
    step(3'd6, 5, 0, FB, 1'b0, p2, 0, 0, '0, "R6 pass b fb");
    step(3'd7, 6, 1, 2, 1'b1, p1, 0, 0, '0, "R8 clear");
    step(3'd0, 2, 1, 2, 1'b0, p2, 0, 0, '0, "R7 R8 add wrap");
    step(3'd0, 0, 3, 4, 1'b1, p2, 0, 0, '0, "R7 add carry chain");
    step(3'd1, 1, 2, 2, 1'b0, p2, 0, 0, '0, "R7 sub borrow");
    step(3'd0, 3, 0, 1, 1'b0, ~p1, 0, 0, '0, "R4 fb hold");
    step(3'd0, FB, 0, 1, 1'b0, p1, 1, 1, 8'hC3, "R9 R10 restore save clash");
    step(3'd2, 0, FB, FB, 1'b0, p2, 1, 0, '0, "R10 save restored");
    step(3'd3, 2, 0, 1, 1'b0, p1, 0, 0, '0, "R10 save hold");
    step(3'd4, 4, 1, 2, 1'b0, p2, 0, 1, 8'h3C, "R9 restore alone");
    step(3'd5, 5, 0, 0, 1'b0, p1, 1, 0, '0, "R4 R10 save after restore");
    repeat (3) @(posedge clk_i);
    #1;
    check("R3 queue drained", 64'(q.size()), 64'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule